// File: doc/BRIEF.md
# 12-bit Instruction Control Decoder

This block turns a 12-bit instruction word of a small accumulator machine into the control word for a datapath in which every result passes through one 2-input ALU. Register moves, clears, bit set, bit clear and bit tests have no path of their own. Each one is coded as an operand-mux choice plus an ALU operation that produces the wanted value. Examples are a copy by OR-ing a value with itself, a clear by XOR-ing W with itself, and a bit update by combining a one-hot mask with the source byte.

The decoder is purely combinational. It drives these outputs:
- operand A select and operand B select;
- the ALU operation;
- write enables for the W register, for the file space, for the zero flag and for the carry flag;
- a mask-inversion flag;
- one-cycle strobes for the option-load word and the tristate-load words.

The following are handled by neighbouring logic and are not part of this block: the program counter, the return stack, skip insertion, file address decoding and the ALU.

Instruction fields are fixed:
- literal = instr[7:0];
- file select = instr[4:0];
- destination bit = instr[5];
- bit number = instr[7:5].

Top module: `instr_ctrl_dec`

## Requirements
- R1: Word 0x000 produces all-zero outputs. Operand A codes are 0=W, 1=source bus, 2=literal, 3=bit mask. Operand B codes are 0=W, 1=source bus, 2=literal, 3=constant one. ALU codes are ADD=0, AND=1, OR=2, XOR=3, COM=4, ROR=5, ROL=6, SWAP=7, SUB=8.
- R2: For byte-file words (instr[11:10]=00, instr[9:6] from 2 to 15), instr[5]=0 asserts only the W write enable and instr[5]=1 asserts only the file write enable.
- R3: When instr[9:6]=2, the word subtracts W from the file (A=source, B=W, SUB) and enables Z and C.
- R4: When instr[9:6]=7, the word adds W and the file (A=W, B=source, ADD) and enables Z and C.
- R5: Increment (instr[9:6]=10) and decrement (instr[9:6]=3) use A=source, B=one, with ADD or SUB respectively, and enable Z only.
- R6: The word groups below all use A=W, B=source and enable Z only:
  - instr[9:6]=4 is OR;
  - instr[9:6]=5 is AND;
  - instr[9:6]=6 is XOR.
- R7: Move-file (instr[9:6]=8) is OR with A=B=source. Complement (instr[9:6]=9) is COM with A=B=source. Both enable Z only.
- R8: Rotate right (instr[9:6]=12) and rotate left (instr[9:6]=13) use A=B=source and enable C only. Nibble swap (instr[9:6]=14) enables no flag.
- R9: Increment-skip (instr[9:6]=15) and decrement-skip (instr[9:6]=11) use A=source, B=one, ADD or SUB respectively, and enable no flag.
- R10: The following words use A=B=W:
  - 0x020..0x03F writes W to the file (OR, file enable);
  - 0x060..0x07F clears the file (XOR, file enable, Z enable);
  - 0x040 clears W (XOR, W enable, Z enable).
- R11: Option-load is 0x002 only. Tristate-load is 0x005..0x007 only. Each is OR with A=B=W and its own strobe and no write enable. Every other word in 0x001..0x01F and 0x041..0x05F gives all-zero outputs.
- R12: Bit words (instr[11:10]=01) select A=mask and B=source:
  - bit clear (instr[9:8]=00) uses AND with mask inversion and file enable;
  - bit set (instr[9:8]=01) uses OR with file enable;
  - bit tests (instr[9:8]=1x) use AND with no enable at all.
- R13: Return-with-literal (instr[11:8]=1000) loads the literal into W using A=B=literal with OR, and no flags. Call (1001) and jump (101x) give all-zero outputs.
- R14: Literal words (instr[11:10]=11) enable W:
  - instr[9:8]=00 is a literal move (A=B=literal, OR, no Z);
  - instr[9:8]=01 is OR, 10 is AND and 11 is XOR, each with A=W, B=literal and Z enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 12 | Instruction word |
| opa_sel_o | output | 2 | ALU operand A select |
| opb_sel_o | output | 2 | ALU operand B select |
| alu_op_o | output | 4 | ALU operation |
| w_we_o | output | 1 | W register write enable |
| f_we_o | output | 1 | File space write enable |
| z_we_o | output | 1 | Zero flag write enable |
| c_we_o | output | 1 | Carry flag write enable |
| mask_inv_o | output | 1 | Invert the one-hot bit mask |
| opt_ld_o | output | 1 | Option-load strobe |
| tris_ld_o | output | 1 | Tristate-load strobe |

## Verification
The hardest cases to reach are the isolated words among the leading 128 codes. Option-load, the three tristate words and the clear-W word each sit beside runs of reserved encodings. A decoder that matches too loosely would still give the right result for most neighbours, so the single-word special cases are checked against every adjacent reserved word. The stimulus covers all 4096 instruction words in sequence, so every such boundary is applied. A bench model built from the field rules above predicts the complete control word for each one.

// File: rtl/instr_dec_pkg.sv
package instr_dec_pkg;
  localparam int INSTR_W = 12;

  typedef enum logic [1:0] {OPA_W = 2'd0, OPA_SRC = 2'd1, OPA_LIT = 2'd2, OPA_MASK = 2'd3} opa_e;
  typedef enum logic [1:0] {OPB_W = 2'd0, OPB_SRC = 2'd1, OPB_LIT = 2'd2, OPB_ONE = 2'd3} opb_e;
  typedef enum logic [3:0] {
    ALU_ADD = 4'd0, ALU_AND = 4'd1, ALU_OR = 4'd2, ALU_XOR = 4'd3,
    ALU_COM = 4'd4, ALU_ROR = 4'd5, ALU_ROL = 4'd6, ALU_SWAP = 4'd7,
    ALU_SUB = 4'd8
  } alu_op_e;

  typedef struct packed {
    opa_e    opa;
    opb_e    opb;
    alu_op_e op;
    logic    w_we;
    logic    f_we;
    logic    z_we;
    logic    c_we;
    logic    mask_inv;
    logic    opt_ld;
    logic    tris_ld;
  } ctrl_t;

  function automatic ctrl_t ctrl_idle();
    ctrl_t c;
    c = '0;
    c.opa = OPA_W;
    c.opb = OPB_W;
    c.op  = ALU_ADD;
    return c;
  endfunction

  function automatic ctrl_t ctrl_alu(opa_e a, opb_e b, alu_op_e op);
    ctrl_t c;
    c = ctrl_idle();
    c.opa = a;
    c.opb = b;
    c.op  = op;
    return c;
  endfunction
endpackage

// File: rtl/byte_op_dec.sv
module byte_op_dec
  import instr_dec_pkg::*;
#(
  parameter int IW = INSTR_W
) (
  input  logic [IW-1:0] instr_i,
  output logic          hit_o,
  output ctrl_t         ctrl_o
);
  localparam int OPC_LSB = IW - 6;
  localparam int DST_BIT = 5;

  logic [3:0] sub_op;
  logic       dst_f;

  assign sub_op = instr_i[OPC_LSB+3:OPC_LSB];
  assign dst_f  = instr_i[DST_BIT];
  assign hit_o  = (instr_i[IW-1:IW-2] == 2'b00) && (sub_op >= 4'd2);

  always_comb begin
    ctrl_o = ctrl_idle();
    if (hit_o) begin
      unique case (sub_op)
        4'd2:  begin ctrl_o = ctrl_alu(OPA_SRC, OPB_W,   ALU_SUB);  ctrl_o.z_we = 1'b1; ctrl_o.c_we = 1'b1; end
        4'd3:  begin ctrl_o = ctrl_alu(OPA_SRC, OPB_ONE, ALU_SUB);  ctrl_o.z_we = 1'b1; end
        4'd4:  begin ctrl_o = ctrl_alu(OPA_W,   OPB_SRC, ALU_OR);   ctrl_o.z_we = 1'b1; end
        4'd5:  begin ctrl_o = ctrl_alu(OPA_W,   OPB_SRC, ALU_AND);  ctrl_o.z_we = 1'b1; end
        4'd6:  begin ctrl_o = ctrl_alu(OPA_W,   OPB_SRC, ALU_XOR);  ctrl_o.z_we = 1'b1; end
        4'd7:  begin ctrl_o = ctrl_alu(OPA_W,   OPB_SRC, ALU_ADD);  ctrl_o.z_we = 1'b1; ctrl_o.c_we = 1'b1; end
        4'd8:  begin ctrl_o = ctrl_alu(OPA_SRC, OPB_SRC, ALU_OR);   ctrl_o.z_we = 1'b1; end
        4'd9:  begin ctrl_o = ctrl_alu(OPA_SRC, OPB_SRC, ALU_COM);  ctrl_o.z_we = 1'b1; end
        4'd10: begin ctrl_o = ctrl_alu(OPA_SRC, OPB_ONE, ALU_ADD);  ctrl_o.z_we = 1'b1; end
        4'd11: ctrl_o = ctrl_alu(OPA_SRC, OPB_ONE, ALU_SUB);
        4'd12: begin ctrl_o = ctrl_alu(OPA_SRC, OPB_SRC, ALU_ROR);  ctrl_o.c_we = 1'b1; end
        4'd13: begin ctrl_o = ctrl_alu(OPA_SRC, OPB_SRC, ALU_ROL);  ctrl_o.c_we = 1'b1; end
        4'd14: ctrl_o = ctrl_alu(OPA_SRC, OPB_SRC, ALU_SWAP);
        default: ctrl_o = ctrl_alu(OPA_SRC, OPB_ONE, ALU_ADD);
      endcase
      ctrl_o.w_we = ~dst_f;
      ctrl_o.f_we = dst_f;
    end
  end

  // R2
  always_comb begin
    if (hit_o) begin
      dest_excl_chk: assert (ctrl_o.w_we ^ ctrl_o.f_we)
        else $error("byte word must write exactly one destination");
    end
  end

  // R8
  always_comb begin
    if (hit_o && (ctrl_o.op inside {ALU_ROR, ALU_ROL})) begin
      rot_flag_chk: assert (ctrl_o.c_we && !ctrl_o.z_we)
        else $error("rotate must enable carry only");
    end
  end
endmodule

// File: rtl/zpage_dec.sv
module zpage_dec
  import instr_dec_pkg::*;
#(
  parameter int IW = INSTR_W
) (
  input  logic [IW-1:0] instr_i,
  output logic          hit_o,
  output ctrl_t         ctrl_o
);
  localparam int LOW_W = 5;

  logic             page_hi;
  logic             dst_f;
  logic [LOW_W-1:0] low;

  assign hit_o   = (instr_i[IW-1:7] == '0);
  assign page_hi = instr_i[6];
  assign dst_f   = instr_i[5];
  assign low     = instr_i[LOW_W-1:0];

  always_comb begin
    ctrl_o = ctrl_idle();
    if (hit_o) begin
      if (!page_hi) begin
        if (dst_f) begin
          ctrl_o      = ctrl_alu(OPA_W, OPB_W, ALU_OR);
          ctrl_o.f_we = 1'b1;
        end else if (low == 5'd2) begin
          ctrl_o        = ctrl_alu(OPA_W, OPB_W, ALU_OR);
          ctrl_o.opt_ld = 1'b1;
        end else if (low >= 5'd5 && low <= 5'd7) begin
          ctrl_o         = ctrl_alu(OPA_W, OPB_W, ALU_OR);
          ctrl_o.tris_ld = 1'b1;
        end
      end else begin
        if (dst_f) begin
          ctrl_o      = ctrl_alu(OPA_W, OPB_W, ALU_XOR);
          ctrl_o.f_we = 1'b1;
          ctrl_o.z_we = 1'b1;
        end else if (low == '0) begin
          ctrl_o      = ctrl_alu(OPA_W, OPB_W, ALU_XOR);
          ctrl_o.w_we = 1'b1;
          ctrl_o.z_we = 1'b1;
        end
      end
    end
  end

  // R11
  always_comb begin
    if (hit_o) begin
      strobe_excl_chk: assert (!(ctrl_o.opt_ld && ctrl_o.tris_ld))
        else $error("option and tristate strobes together");
      strobe_quiet_chk: assert (!(ctrl_o.opt_ld || ctrl_o.tris_ld) ||
                                !(ctrl_o.w_we || ctrl_o.f_we || ctrl_o.z_we))
        else $error("load strobe with a write enable");
    end
  end
endmodule

// File: rtl/bit_op_dec.sv
module bit_op_dec
  import instr_dec_pkg::*;
#(
  parameter int IW = INSTR_W
) (
  input  logic [IW-1:0] instr_i,
  output logic          hit_o,
  output ctrl_t         ctrl_o
);
  logic [1:0] kind;

  assign hit_o = (instr_i[IW-1:IW-2] == 2'b01);
  assign kind  = instr_i[IW-3:IW-4];

  always_comb begin
    ctrl_o = ctrl_idle();
    if (hit_o) begin
      unique case (kind)
        2'b00: begin
          ctrl_o          = ctrl_alu(OPA_MASK, OPB_SRC, ALU_AND);
          ctrl_o.mask_inv = 1'b1;
          ctrl_o.f_we     = 1'b1;
        end
        2'b01: begin
          ctrl_o      = ctrl_alu(OPA_MASK, OPB_SRC, ALU_OR);
          ctrl_o.f_we = 1'b1;
        end
        default: ctrl_o = ctrl_alu(OPA_MASK, OPB_SRC, ALU_AND);
      endcase
    end
  end

  // R12
  always_comb begin
    if (hit_o && kind[1]) begin
      bit_test_quiet_chk: assert (!ctrl_o.w_we && !ctrl_o.f_we && !ctrl_o.mask_inv)
        else $error("bit test must not write");
    end
  end
endmodule

// File: rtl/lit_ctl_dec.sv
module lit_ctl_dec
  import instr_dec_pkg::*;
#(
  parameter int IW = INSTR_W
) (
  input  logic [IW-1:0] instr_i,
  output logic          hit_o,
  output ctrl_t         ctrl_o
);
  logic [2:0] kind;

  assign hit_o = instr_i[IW-1];
  assign kind  = instr_i[IW-2:IW-4];

  always_comb begin
    ctrl_o = ctrl_idle();
    if (hit_o) begin
      unique case (kind)
        3'b000: begin ctrl_o = ctrl_alu(OPA_LIT, OPB_LIT, ALU_OR);  ctrl_o.w_we = 1'b1; end
        3'b100: begin ctrl_o = ctrl_alu(OPA_LIT, OPB_LIT, ALU_OR);  ctrl_o.w_we = 1'b1; end
        3'b101: begin ctrl_o = ctrl_alu(OPA_W, OPB_LIT, ALU_OR);  ctrl_o.w_we = 1'b1; ctrl_o.z_we = 1'b1; end
        3'b110: begin ctrl_o = ctrl_alu(OPA_W, OPB_LIT, ALU_AND); ctrl_o.w_we = 1'b1; ctrl_o.z_we = 1'b1; end
        3'b111: begin ctrl_o = ctrl_alu(OPA_W, OPB_LIT, ALU_XOR); ctrl_o.w_we = 1'b1; ctrl_o.z_we = 1'b1; end
        default: ctrl_o = ctrl_idle();
      endcase
    end
  end

  // R13
  always_comb begin
    if (hit_o && !kind[2] && (kind != 3'b000)) begin
      branch_quiet_chk: assert (!ctrl_o.w_we && !ctrl_o.f_we && !ctrl_o.z_we && !ctrl_o.c_we)
        else $error("call/jump must not write");
    end
  end
endmodule

// File: rtl/instr_ctrl_dec.sv
module instr_ctrl_dec
  import instr_dec_pkg::*;
#(
  parameter int IW = INSTR_W
) (
  input  logic [IW-1:0] instr_i,
  output logic [1:0]    opa_sel_o,
  output logic [1:0]    opb_sel_o,
  output logic [3:0]    alu_op_o,
  output logic          w_we_o,
  output logic          f_we_o,
  output logic          z_we_o,
  output logic          c_we_o,
  output logic          mask_inv_o,
  output logic          opt_ld_o,
  output logic          tris_ld_o
);
  localparam int N_DEC = 4;

  logic  [N_DEC-1:0] hit;
  ctrl_t             sub_ctrl [N_DEC];
  ctrl_t             ctrl;

  byte_op_dec #(.IW(IW)) u_byte (.instr_i(instr_i), .hit_o(hit[0]), .ctrl_o(sub_ctrl[0]));
  zpage_dec   #(.IW(IW)) u_zpg  (.instr_i(instr_i), .hit_o(hit[1]), .ctrl_o(sub_ctrl[1]));
  bit_op_dec  #(.IW(IW)) u_bit  (.instr_i(instr_i), .hit_o(hit[2]), .ctrl_o(sub_ctrl[2]));
  lit_ctl_dec #(.IW(IW)) u_lit  (.instr_i(instr_i), .hit_o(hit[3]), .ctrl_o(sub_ctrl[3]));

  // Sub-decoders output idle when not hit, so an OR merge is exact.
  always_comb begin
    ctrl = '0;
    for (int i = 0; i < N_DEC; i++) ctrl = ctrl | sub_ctrl[i];
  end

  assign opa_sel_o  = ctrl.opa;
  assign opb_sel_o  = ctrl.opb;
  assign alu_op_o   = ctrl.op;
  assign w_we_o     = ctrl.w_we;
  assign f_we_o     = ctrl.f_we;
  assign z_we_o     = ctrl.z_we;
  assign c_we_o     = ctrl.c_we;
  assign mask_inv_o = ctrl.mask_inv;
  assign opt_ld_o   = ctrl.opt_ld;
  assign tris_ld_o  = ctrl.tris_ld;

  // R1
  always_comb begin
    class_onehot_chk: assert ($onehot(hit))
      else $error("instruction claimed by %0d sub-decoders", $countones(hit));
  end

  // R12
  always_comb begin
    if (mask_inv_o) begin
      mask_inv_src_chk: assert (opa_sel_o == OPA_MASK && alu_op_o == ALU_AND)
        else $error("mask inversion outside bit clear");
    end
  end

  // R3
  always_comb begin
    if (c_we_o) begin
      carry_op_chk: assert (alu_op_o inside {ALU_ADD, ALU_SUB, ALU_ROR, ALU_ROL})
        else $error("carry enable with non-carry op");
    end
  end
endmodule

// File: tb/sim_instr_ctrl_dec.sv
`timescale 1ns/1ps
module sim_instr_ctrl_dec;
  logic        clk = 1'b0;
  logic [11:0] instr;
  logic [1:0]  opa, opb;
  logic [3:0]  op;
  logic        w_we, f_we, z_we, c_we, minv, opt, tris;
  int          n_vec = 0;
  int          n_bad = 0;
  bit          done  = 1'b0;

  always #5 clk = ~clk;

  instr_ctrl_dec u0 (
    .instr_i(instr), .opa_sel_o(opa), .opb_sel_o(opb), .alu_op_o(op),
    .w_we_o(w_we), .f_we_o(f_we), .z_we_o(z_we), .c_we_o(c_we),
    .mask_inv_o(minv), .opt_ld_o(opt), .tris_ld_o(tris)
  );

  localparam logic [3:0] ADD = 0, AND_ = 1, OR_ = 2, XOR_ = 3, COM = 4,
                         ROR = 5, ROL = 6, SWP = 7, SUB = 8;

  // Packed expectation: {a,b,op,w,f,z,c,inv,opt,tris}
  function automatic logic [14:0] model(input logic [11:0] iw, output string req);
    logic [1:0] a = 0, b = 0;
    logic [3:0] o = 0;
    logic ww = 0, fw = 0, zw = 0, cw = 0, inv = 0, ol = 0, tl = 0;
    logic [3:0] sub = iw[9:6];
    req = "R1";
    if (iw[11:10] == 2'b00 && sub >= 2) begin
      ww = ~iw[5]; fw = iw[5];
      case (sub)
        2:  begin a = 1; b = 0; o = SUB; zw = 1; cw = 1; req = "R3"; end
        3:  begin a = 1; b = 3; o = SUB; zw = 1; req = "R5"; end
        4:  begin a = 0; b = 1; o = OR_;  zw = 1; req = "R6"; end
        5:  begin a = 0; b = 1; o = AND_; zw = 1; req = "R6"; end
        6:  begin a = 0; b = 1; o = XOR_; zw = 1; req = "R6"; end
        7:  begin a = 0; b = 1; o = ADD; zw = 1; cw = 1; req = "R4"; end
        8:  begin a = 1; b = 1; o = OR_; zw = 1; req = "R7"; end
        9:  begin a = 1; b = 1; o = COM; zw = 1; req = "R7"; end
        10: begin a = 1; b = 3; o = ADD; zw = 1; req = "R5"; end
        11: begin a = 1; b = 3; o = SUB; req = "R9"; end
        12: begin a = 1; b = 1; o = ROR; cw = 1; req = "R8"; end
        13: begin a = 1; b = 1; o = ROL; cw = 1; req = "R8"; end
        14: begin a = 1; b = 1; o = SWP; req = "R8"; end
        default: begin a = 1; b = 3; o = ADD; req = "R9"; end
      endcase
      if (sub != 2 && req != "R2") req = {req, "/R2"};
    end else if (iw[11:6] == 6'd0) begin
      if (iw[5]) begin o = OR_; fw = 1; req = "R10"; end
      else if (iw[4:0] == 2) begin o = OR_; ol = 1; req = "R11"; end
      else if (iw[4:0] >= 5 && iw[4:0] <= 7) begin o = OR_; tl = 1; req = "R11"; end
      else if (iw != 0) req = "R11";
    end else if (iw[11:6] == 6'd1) begin
      if (iw[5]) begin o = XOR_; fw = 1; zw = 1; req = "R10"; end
      else if (iw[4:0] == 0) begin o = XOR_; ww = 1; zw = 1; req = "R10"; end
      else req = "R11";
    end else if (iw[11:10] == 2'b01) begin
      a = 3; b = 1; req = "R12";
      case (iw[9:8])
        0: begin o = AND_; inv = 1; fw = 1; end
        1: begin o = OR_; fw = 1; end
        default: o = AND_;
      endcase
    end else if (iw[11:10] == 2'b10) begin
      req = "R13";
      if (iw[9:8] == 0) begin a = 2; b = 2; o = OR_; ww = 1; end
    end else begin
      req = "R14"; ww = 1;
      case (iw[9:8])
        0: begin a = 2; b = 2; o = OR_; end
        1: begin a = 0; b = 2; o = OR_;  zw = 1; end
        2: begin a = 0; b = 2; o = AND_; zw = 1; end
        default: begin a = 0; b = 2; o = XOR_; zw = 1; end
      endcase
    end
    return {a, b, o, ww, fw, zw, cw, inv, ol, tl};
  endfunction

  task automatic apply(input logic [11:0] iw);
    logic [14:0] exp_v, act_v;
    string req;
    @(posedge clk);
    instr = iw;
    @(negedge clk);
    exp_v = model(iw, req);
    act_v = {opa, opb, op, w_we, f_we, z_we, c_we, minv, opt, tris};
    n_vec++;
    if (act_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s instr=%03h actual=%04h expected=%04h", req, iw, act_v, exp_v);
    end
  endtask

  initial begin
    instr = 12'h000;
    // R1: idle word first
    apply(12'h000);
    // R2..R14: every word in turn
    for (int i = 1; i < 4096; i++) apply(12'(i));
    // R11: revisit the isolated strobe words and their neighbours
    for (int i = 0; i < 9; i++) apply(12'(i));
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(10 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule